// File: doc/BRIEF.md
# System Clock Control Register

This block is an 8-bit control register for the system clock. It is write-protected, and several of its bits have hardware side effects. A bus write lands in it only when the write address matches the register address and an external protect-enable bit is 1. Several bits are then forced by hardware:

- While the sub-oscillator port enable is clear, the sub-oscillator drive bit is held high.
- While the main-oscillator stop bit is set, the divide-by-8 flag is held high.
- A stop-mode entry pulse raises the drive bit.
- The same pulse raises the divide-by-8 flag when the core is running in high- or middle-speed mode.

Reading the register returns the effective value, which is the value after these forcings and not the raw value written.

The register bits drive several control outputs:

- the CPU clock source select;
- the main-oscillator stop;
- the divide-by-8 flag;
- the sub-oscillator enable and its drive strength;
- the wait-mode gate for peripheral clocks;
- the hold on a companion drive bit in a neighbouring register.

The two low bits choose what appears on a clock-output pin: a general port value, the sub-clock, or one of two divided clocks. This choice applies only in single-chip mode. All clocks are modelled as level or enable inputs.

Top module: `sysclk_ctrl`

## Requirements
- R1: After synchronous reset the readback `rd_value` is 8'h48 and `clk_out_pin` is 0.
- R2: A write with `wr_en`=1, `prot_en`=1 and `wr_addr`=8'h06 updates the register at the next rising edge. A write to any other address leaves `rd_value` unchanged.
- R3: A write with `prot_en`=0 is ignored, and `rd_value` keeps its previous value.
- R4: Whenever bit 4 (sub-oscillator port enable) reads 0, bit 3 (sub-oscillator drive, 1 = high) reads 1.
- R5: While bit 5 (main-oscillator stop) is 1, bit 6 (divide-by-8 mode) reads 1 even if 0 was written, and `cm15_hold` is 1.
- R6: A `stop_entry` pulse sets bit 3 to 1. The pulse also sets bit 6 to 1 when `speed_mode` is 2'b00 (high) or 2'b01 (middle). With `speed_mode` 2'b10 or 2'b11 (low, low-power), bit 6 is left as it was.
- R7: The outputs are the register bits: `cpu_clk_sub`=bit 7 (1 = sub-clock), `main_osc_stop`=bit 5, `div8_mode`=bit 6, `sub_osc_en`=bit 4, `sub_drive_high`=bit 3 and `peri_stop_in_wait`=bit 2.
- R8: In single-chip mode, bits [1:0] select `clk_out_pin` one cycle after the inputs settle: 2'b00 gives `port_out`, 2'b01 gives `clk_fc`, 2'b10 gives `clk_f8`, and 2'b11 gives `clk_f32`.
- R9: When `single_chip` is 0, `clk_out_pin` follows `port_out` whatever bits [1:0] hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| prot_en | input | 1 | Protect enable; 1 permits writes |
| stop_entry | input | 1 | One-cycle pulse on entry to stop mode |
| speed_mode | input | 2 | Current speed: 00 high, 01 middle, 10 low, 11 low-power |
| single_chip | input | 1 | 1 when in single-chip mode |
| port_out | input | 1 | General port value for the output pin |
| clk_fc | input | 1 | Sub-clock level |
| clk_f8 | input | 1 | Divide-by-8 peripheral clock level |
| clk_f32 | input | 1 | Divide-by-32 peripheral clock level |
| rd_value | output | 8 | Effective register value |
| clk_out_pin | output | 1 | Registered clock-output pin |
| cpu_clk_sub | output | 1 | CPU clock source, 1 = sub-clock |
| main_osc_stop | output | 1 | Main oscillator stop |
| div8_mode | output | 1 | Divide-by-8 mode in force |
| sub_osc_en | output | 1 | Sub-oscillator function enabled |
| sub_drive_high | output | 1 | Sub-oscillator high drive |
| peri_stop_in_wait | output | 1 | Stop peripheral clocks in wait mode |
| cm15_hold | output | 1 | Holds the companion drive bit high |

## Verification
A write or a stop-entry pulse driven before a rising edge shows up in `rd_value` and in the control outputs right after that edge, with the forcings already applied. The bench therefore drives on the falling edge and checks at the following falling edge. The clock-output pin takes one more register stage, since it samples the stored select together with the clock-level inputs. After a write, the bench sets the clock levels and waits one further edge before checking the pin. Each checked level pattern is chosen so that a wrong selection would give a different pin value.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W = 8;
  localparam int B_SEL0 = 0;
  localparam int B_SEL1 = 1;
  localparam int B_PSTOP = 2;
  localparam int B_DRV = 3;
  localparam int B_SUBEN = 4;
  localparam int B_MSTOP = 5;
  localparam int B_DIV8 = 6;
  localparam int B_CSRC = 7;

  typedef enum logic [1:0] {
    OUT_PORT = 2'b00,
    OUT_FC   = 2'b01,
    OUT_F8   = 2'b10,
    OUT_F32  = 2'b11
  } out_sel_e;

  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_LPWR = 2'b11
  } speed_e;
endpackage

// File: rtl/sysclk_wr_dec.sv
module sysclk_wr_dec #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h06
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              prot_en,
  output logic              wr_hit
);
  always_comb begin
    wr_hit = wr_en && prot_en && (wr_addr == REG_ADDR);
  end
endmodule

// File: rtl/sysclk_reg_core.sv
module sysclk_reg_core
  import sysclk_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = 8'h48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wr_data,
  input  logic             stop_entry,
  input  logic [1:0]       speed_mode,
  output logic [REG_W-1:0] reg_q
);
  logic [REG_W-1:0] nxt;
  logic             fast_speed;

  always_comb begin
    fast_speed = (speed_mode == SPD_HIGH) || (speed_mode == SPD_MID);
    nxt = wr_hit ? wr_data : reg_q;
    // hardware forcing, applied after any write in the same cycle
    if (!nxt[B_SUBEN]) nxt[B_DRV] = 1'b1;
    if (nxt[B_MSTOP]) nxt[B_DIV8] = 1'b1;
    if (stop_entry) begin
      nxt[B_DRV] = 1'b1;
      if (fast_speed) nxt[B_DIV8] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_q <= RESET_VAL;
    else     reg_q <= nxt;
  end
endmodule

// File: rtl/sysclk_out_mux.sv
module sysclk_out_mux
  import sysclk_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       single_chip,
  input  logic       port_out,
  input  logic       clk_fc,
  input  logic       clk_f8,
  input  logic       clk_f32,
  output logic       pin_q
);
  localparam int SEL_W = $clog2(N_SRC);
  logic [N_SRC-1:0] src;
  logic [SEL_W-1:0] idx;

  assign src[OUT_PORT] = port_out;
  assign src[OUT_FC]   = clk_fc;
  assign src[OUT_F8]   = clk_f8;
  assign src[OUT_F32]  = clk_f32;

  always_comb idx = single_chip ? sel : SEL_W'(OUT_PORT);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= src[idx];
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h06,
  parameter logic [7:0] RESET_VAL = 8'h48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prot_en,
  input  logic              stop_entry,
  input  logic [1:0]        speed_mode,
  input  logic              single_chip,
  input  logic              port_out,
  input  logic              clk_fc,
  input  logic              clk_f8,
  input  logic              clk_f32,
  output logic [7:0]        rd_value,
  output logic              clk_out_pin,
  output logic              cpu_clk_sub,
  output logic              main_osc_stop,
  output logic              div8_mode,
  output logic              sub_osc_en,
  output logic              sub_drive_high,
  output logic              peri_stop_in_wait,
  output logic              cm15_hold
);
  logic             wr_hit;
  logic [REG_W-1:0] reg_q;

  sysclk_wr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .prot_en(prot_en), .wr_hit(wr_hit)
  );

  sysclk_reg_core #(.RESET_VAL(RESET_VAL)) u_core (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_data(wr_data),
    .stop_entry(stop_entry), .speed_mode(speed_mode), .reg_q(reg_q)
  );

  sysclk_out_mux #(.N_SRC(4)) u_mux (
    .clk(clk), .rst(rst), .sel(reg_q[B_SEL1:B_SEL0]),
    .single_chip(single_chip), .port_out(port_out), .clk_fc(clk_fc),
    .clk_f8(clk_f8), .clk_f32(clk_f32), .pin_q(clk_out_pin)
  );

  assign rd_value          = reg_q;
  assign cpu_clk_sub       = reg_q[B_CSRC];
  assign main_osc_stop     = reg_q[B_MSTOP];
  assign div8_mode         = reg_q[B_DIV8];
  assign sub_osc_en        = reg_q[B_SUBEN];
  assign sub_drive_high    = reg_q[B_DRV];
  assign peri_stop_in_wait = reg_q[B_PSTOP];
  assign cm15_hold         = reg_q[B_MSTOP];
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h06
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              prot_en,
  input logic              stop_entry,
  input logic [1:0]        speed_mode,
  input logic              single_chip,
  input logic              port_out,
  input logic              clk_f8,
  input logic              clk_f32,
  input logic [7:0]        rd_value,
  input logic              clk_out_pin,
  input logic              cm15_hold
);
  a_r2_write_bit7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && prot_en && wr_addr == REG_ADDR) |=> rd_value[7] == $past(wr_data[7]));

  a_r3_protected: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !prot_en && !stop_entry) |=> $stable(rd_value));

  a_r4_drive_forced: assert property (@(posedge clk) disable iff (rst)
    !rd_value[4] |-> rd_value[3]);

  a_r5_div8_held: assert property (@(posedge clk) disable iff (rst)
    rd_value[5] |-> (rd_value[6] && cm15_hold));

  a_r6_stop_fast: assert property (@(posedge clk) disable iff (rst)
    (stop_entry && !speed_mode[1]) |=> (rd_value[6] && rd_value[3]));

  a_r8_sel_f8: assert property (@(posedge clk) disable iff (rst)
    (single_chip && rd_value[1:0] == 2'b10) |=> clk_out_pin == $past(clk_f8));

  a_r8_sel_f32: assert property (@(posedge clk) disable iff (rst)
    (single_chip && rd_value[1:0] == 2'b11) |=> clk_out_pin == $past(clk_f32));

  a_r9_port_mode: assert property (@(posedge clk) disable iff (rst)
    !single_chip |=> clk_out_pin == $past(port_out));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .prot_en(prot_en), .stop_entry(stop_entry), .speed_mode(speed_mode),
  .single_chip(single_chip), .port_out(port_out), .clk_f8(clk_f8),
  .clk_f32(clk_f32), .rd_value(rd_value), .clk_out_pin(clk_out_pin),
  .cm15_hold(cm15_hold)
);

// File: tb/sysclk_ctrl_tb.sv
module sysclk_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic prot_en = 1'b1;
  logic stop_entry = 1'b0;
  logic [1:0] speed_mode = 2'b00;
  logic single_chip = 1'b1;
  logic port_out = 1'b0, clk_fc = 1'b0, clk_f8 = 1'b0, clk_f32 = 1'b0;
  logic [7:0] rd_value;
  logic clk_out_pin, cpu_clk_sub, main_osc_stop, div8_mode, sub_osc_en;
  logic sub_drive_high, peri_stop_in_wait, cm15_hold;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysclk_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prot_en(prot_en), .stop_entry(stop_entry), .speed_mode(speed_mode),
    .single_chip(single_chip), .port_out(port_out), .clk_fc(clk_fc),
    .clk_f8(clk_f8), .clk_f32(clk_f32), .rd_value(rd_value),
    .clk_out_pin(clk_out_pin), .cpu_clk_sub(cpu_clk_sub),
    .main_osc_stop(main_osc_stop), .div8_mode(div8_mode),
    .sub_osc_en(sub_osc_en), .sub_drive_high(sub_drive_high),
    .peri_stop_in_wait(peri_stop_in_wait), .cm15_hold(cm15_hold)
  );

  // {written value, expected readback}
  localparam logic [15:0] VEC [9] = '{
    {8'h00, 8'h08}, {8'h10, 8'h10}, {8'h30, 8'h70}, {8'h90, 8'h90},
    {8'h14, 8'h14}, {8'hFF, 8'hFF}, {8'h07, 8'h0F}, {8'hD3, 8'hD3},
    {8'h23, 8'h6B}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; prot_en = p;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; prot_en = 1'b1;
  endtask

  task automatic stop_pulse(input logic [1:0] spd);
    @(negedge clk);
    speed_mode = spd; stop_entry = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_entry = 1'b0;
  endtask

  task automatic pin_chk(input string req, input logic po, input logic fc,
                         input logic f8, input logic f32, input logic exp);
    port_out = po; clk_fc = fc; clk_f8 = f8; clk_f32 = f32;
    @(posedge clk);
    @(negedge clk);
    chk(req, {7'd0, clk_out_pin}, {7'd0, exp});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset value", rd_value, 8'h48);
    chk("R1 reset pin", {7'd0, clk_out_pin}, 8'h00);

    // table walk: R2 write, R4/R5 forcing on readback
    foreach (VEC[i]) begin
      wr(8'h06, VEC[i][15:8], 1'b1);
      chk("R2/R4/R5 vector readback", rd_value, VEC[i][7:0]);
    end

    // R3: protected write ignored from reset value
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    wr(8'h06, 8'h90, 1'b0);
    chk("R3 protect off keeps reset", rd_value, 8'h48);
    // R2: wrong address ignored
    wr(8'h07, 8'h90, 1'b1);
    chk("R2 other address ignored", rd_value, 8'h48);

    // R5: main stop set, then clear bit6 -> still 1
    wr(8'h06, 8'h30, 1'b1);
    wr(8'h06, 8'h30, 1'b1);
    chk("R5 bit6 held with bit5", rd_value, 8'h70);
    chk("R5 cm15 hold", {7'd0, cm15_hold}, 8'h01);

    // R7 output mapping: 0xD4 = bits 7,6,4,2
    wr(8'h06, 8'hD4, 1'b1);
    chk("R7 outputs", {cpu_clk_sub, div8_mode, main_osc_stop, sub_osc_en,
                       sub_drive_high, peri_stop_in_wait, 2'b00}, 8'hD4);

    // R6 stop entry
    wr(8'h06, 8'h10, 1'b1);
    stop_pulse(2'b00);
    chk("R6 stop from high", rd_value, 8'h58);
    wr(8'h06, 8'h10, 1'b1);
    stop_pulse(2'b01);
    chk("R6 stop from middle", rd_value, 8'h58);
    wr(8'h06, 8'h10, 1'b1);
    stop_pulse(2'b10);
    chk("R6 stop from low keeps bit6", rd_value, 8'h18);

    // R8 mux codes (bit4 set to keep bits clean)
    single_chip = 1'b1;
    wr(8'h06, 8'h10, 1'b1);
    pin_chk("R8 code00 port", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    pin_chk("R8 code00 port low", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    wr(8'h06, 8'h11, 1'b1);
    pin_chk("R8 code01 fc", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    pin_chk("R8 code01 fc low", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    wr(8'h06, 8'h12, 1'b1);
    pin_chk("R8 code10 f8", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    pin_chk("R8 code10 f8 low", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    wr(8'h06, 8'h13, 1'b1);
    pin_chk("R8 code11 f32", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    pin_chk("R8 code11 f32 low", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

    // R9 not single-chip: port value regardless of code 11
    single_chip = 1'b0;
    pin_chk("R9 port in other mode", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    pin_chk("R9 port low in other mode", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule